// File: doc/BRIEF.md
# Non-Restoring Division Step Unit

This block performs one iteration of non-restoring binary division per command and keeps three persistent status bits between commands. The bits are Q, the sign of the partial remainder, M, the sign of the divisor, and T, the quotient bit just produced. A controller can drive the unit one step at a time: it issues a setup command, then a step command for each quotient bit, and shifts the T bits into a quotient itself. For unsigned division the setup clears all three bits. For signed division the setup loads Q and M from the operand sign bits.

An optional built-in sequencer runs a complete unsigned 32/32 division in response to a single command. The sequencer loads the dividend into a quotient register and clears the partial remainder. It then makes 32 passes. In each pass it performs one division step and rotates the quotient register left through T. At the end it raises a done pulse, and the quotient register then holds the quotient. The block does not correct the remainder for signed division and does not detect a zero divisor.

Top module: `nr_div_unit`

## Requirements
- R1: After reset, rem_out, quot, q_flag, m_flag, t_flag, busy and done are all 0.
- R2: Unsigned setup (start with op=2'b01) clears q_flag, m_flag and t_flag on the next clock edge and leaves rem_out unchanged.
- R3: Signed setup (start with op=2'b10) loads q_flag with rem_in[31] and m_flag with divisor[31], sets t_flag to their XOR, and leaves rem_out unchanged.
- R4: A step (start with op=2'b00) forms S = {rem_in[30:0], t_flag}. If q_flag equals m_flag, rem_out becomes S minus divisor; otherwise rem_out becomes S plus divisor (modulo 2^32). The result is visible after the next clock edge.
- R5: After a step, q_flag equals rem_in[31] XOR the carry-out of the addition (or the borrow of the subtraction) XOR m_flag, and m_flag is unchanged.
- R6: After a step, t_flag is 1 exactly when the new q_flag equals m_flag.
- R7: A run command (start with op=2'b11 while idle) holds busy high for exactly 32 cycles, starting after the launching edge. done is a single-cycle pulse in the cycle in which busy falls.
- R8: During the done pulse of a run, quot equals the unsigned quotient of the rem_in value at launch divided by divisor, for any nonzero divisor.
- R9: While busy is high, start is ignored whatever the op is: m_flag stays 0 and the quotient of the run still comes out correct.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Execute the command on op this cycle |
| op | input | 2 | 00 step, 01 unsigned setup, 10 signed setup, 11 full run |
| rem_in | input | 32 | Partial remainder for a step; dividend for a run or signed setup |
| divisor | input | 32 | Divisor; must be held stable during a run |
| rem_out | output | 32 | Partial remainder register |
| q_flag | output | 1 | Partial-remainder sign status bit |
| m_flag | output | 1 | Divisor sign status bit |
| t_flag | output | 1 | Quotient bit / T status bit |
| quot | output | 32 | Quotient register of the sequencer |
| busy | output | 1 | Sequencer running |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
The properties assume that divisor is held constant for the whole of a run, because the sequencer reads that port on every pass. They also assume that a run is launched only with a nonzero divisor, since a zero divisor is outside the scope of the block. The stimulus meets both assumptions in three ways. It drives the divisor once, at launch, and leaves it alone until done. It forces the low bit of every random run divisor to 1. During a run it changes only start, op and rem_in, and rem_in is read only at launch.

// File: rtl/nr_div_pkg.sv
package nr_div_pkg;
   typedef enum logic [1:0] {
      OP_STEP = 2'b00,
      OP_SETU = 2'b01,
      OP_SETS = 2'b10,
      OP_RUN  = 2'b11
   } nrd_op_e;
endpackage

// File: rtl/nr_div_step.sv
// One non-restoring iteration, purely combinational.
module nr_div_step #(
   parameter int W = 32
) (
   input  logic [W-1:0] rem,
   input  logic [W-1:0] dvs,
   input  logic         q_in,
   input  logic         m_in,
   input  logic         t_in,
   output logic [W-1:0] rem_nx,
   output logic         q_nx,
   output logic         t_nx
);
   logic [W-1:0] shifted;
   logic [W:0]   wide;
   logic         do_sub;

   always_comb begin
      shifted = {rem[W-2:0], t_in};
      do_sub  = (q_in == m_in);
      if (do_sub)
         wide = {1'b0, shifted} - {1'b0, dvs};
      else
         wide = {1'b0, shifted} + {1'b0, dvs};
      rem_nx = wide[W-1:0];
      // wide[W] is the borrow when subtracting and the carry when adding
      q_nx   = rem[W-1] ^ wide[W] ^ m_in;
      t_nx   = (q_nx == m_in);
   end
endmodule

// File: rtl/nr_div_seq.sv
// Pass counter and quotient rotate register for a full unsigned run.
module nr_div_seq #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         launch,
   input  logic [W-1:0] dividend,
   input  logic         bit_in,
   output logic         busy,
   output logic         done,
   output logic [W-1:0] quot,
   output logic         bit_out
);
   localparam int CW = $clog2(W);
   localparam logic [CW-1:0] LAST = CW'(W - 1);

   logic [CW-1:0] pass_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pass_q <= '0;
         busy   <= 1'b0;
         done   <= 1'b0;
         quot   <= '0;
      end else begin
         done <= 1'b0;
         if (launch) begin
            pass_q <= '0;
            busy   <= 1'b1;
            // first rotate through a cleared T
            quot   <= {dividend[W-2:0], 1'b0};
         end else if (busy) begin
            quot <= {quot[W-2:0], bit_in};
            if (pass_q == LAST) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
            pass_q <= pass_q + 1'b1;
         end
      end
   end

   assign bit_out = quot[W-1];
endmodule

// File: rtl/nr_div_unit.sv
module nr_div_unit #(
   parameter int W      = 32,
   parameter bit SEQ_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [1:0]   op,
   input  logic [W-1:0] rem_in,
   input  logic [W-1:0] divisor,
   output logic [W-1:0] rem_out,
   output logic         q_flag,
   output logic         m_flag,
   output logic         t_flag,
   output logic [W-1:0] quot,
   output logic         busy,
   output logic         done
);
   import nr_div_pkg::*;

   if (W < 2) begin : g_bad_width
      $error("nr_div_unit: W must be at least 2");
   end

   nrd_op_e      cmd;
   logic         idle_go;
   logic         go_run;
   logic [W-1:0] step_src;
   logic [W-1:0] rem_nx;
   logic         q_nx;
   logic         t_nx;
   logic         rot_bit;

   assign cmd      = nrd_op_e'(op);
   assign idle_go  = start && !busy;
   assign go_run   = idle_go && (cmd == OP_RUN) && SEQ_EN;
   assign step_src = busy ? rem_out : rem_in;

   nr_div_step #(.W(W)) step_i (
      .rem    (step_src),
      .dvs    (divisor),
      .q_in   (q_flag),
      .m_in   (m_flag),
      .t_in   (t_flag),
      .rem_nx (rem_nx),
      .q_nx   (q_nx),
      .t_nx   (t_nx)
   );

   if (SEQ_EN) begin : g_seq
      nr_div_seq #(.W(W)) seq_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .launch   (go_run),
         .dividend (rem_in),
         .bit_in   (t_nx),
         .busy     (busy),
         .done     (done),
         .quot     (quot),
         .bit_out  (rot_bit)
      );
   end else begin : g_noseq
      assign busy    = 1'b0;
      assign done    = 1'b0;
      assign quot    = '0;
      assign rot_bit = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_out <= '0;
         q_flag  <= 1'b0;
         m_flag  <= 1'b0;
         t_flag  <= 1'b0;
      end else if (go_run) begin
         rem_out <= '0;
         q_flag  <= 1'b0;
         m_flag  <= 1'b0;
         t_flag  <= rem_in[W-1];
      end else if (busy) begin
         rem_out <= rem_nx;
         q_flag  <= q_nx;
         t_flag  <= rot_bit;
      end else if (idle_go) begin
         case (cmd)
            OP_STEP: begin
               rem_out <= rem_nx;
               q_flag  <= q_nx;
               t_flag  <= t_nx;
            end
            OP_SETU: begin
               q_flag <= 1'b0;
               m_flag <= 1'b0;
               t_flag <= 1'b0;
            end
            OP_SETS: begin
               q_flag <= rem_in[W-1];
               m_flag <= divisor[W-1];
               t_flag <= rem_in[W-1] ^ divisor[W-1];
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/nr_div_chk.sv
module nr_div_chk #(
   parameter int W = 32
) (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic [1:0] op,
   input logic       rem_msb,
   input logic       div_msb,
   input logic       busy,
   input logic       done,
   input logic       q_flag,
   input logic       m_flag,
   input logic       t_flag
);
   localparam int CW = $clog2(W + 1);

   logic [CW-1:0] busy_cnt;
   logic          idle_cmd;

   assign idle_cmd = start && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_cnt <= '0;
      else if (busy) busy_cnt <= busy_cnt + 1'b1;
      else           busy_cnt <= '0;
   end

   p_setu_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      idle_cmd && op == 2'b01 |=> !q_flag && !m_flag && !t_flag);

   p_sets_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      idle_cmd && op == 2'b10 |=> q_flag == $past(rem_msb) &&
                                   m_flag == $past(div_msb) &&
                                   t_flag == (q_flag ^ m_flag));

   p_step_m_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      idle_cmd && op == 2'b00 |=> $stable(m_flag));

   p_step_t_r6: assert property (@(posedge clk) disable iff (!rst_n)
      idle_cmd && op == 2'b00 |=> t_flag == (q_flag == m_flag));

   p_done_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && busy_cnt == CW'(W));

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_busy_m_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !m_flag);
endmodule

bind nr_div_unit nr_div_chk #(.W(W)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .op      (op),
   .rem_msb (rem_in[W-1]),
   .div_msb (divisor[W-1]),
   .busy    (busy),
   .done    (done),
   .q_flag  (q_flag),
   .m_flag  (m_flag),
   .t_flag  (t_flag)
);

// File: tb/nr_div_unit_tb_top.sv
`timescale 1ns/1ps
module nr_div_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  op = 2'b00;
   logic [31:0] rem_in = '0;
   logic [31:0] divisor = '0;
   logic [31:0] rem_out;
   logic        q_flag, m_flag, t_flag;
   logic [31:0] quot;
   logic        busy, done;

   int nchk = 0;
   int nfail = 0;

   // model status bits
   logic mq = 1'b0, mm = 1'b0, mt = 1'b0;

   always #10 clk = ~clk;

   nr_div_unit #(.W(32), .SEQ_EN(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op),
      .rem_in(rem_in), .divisor(divisor), .rem_out(rem_out),
      .q_flag(q_flag), .m_flag(m_flag), .t_flag(t_flag),
      .quot(quot), .busy(busy), .done(done)
   );

   task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s act=%h exp=%h", rq, act, exp);
      end
   endtask

   // expected step result per R4/R5/R6: {rem, q, t}
   function automatic logic [33:0] ref_step(input logic [31:0] r, input logic [31:0] d,
                                            input logic q, input logic m, input logic t);
      logic [32:0] s;
      logic [31:0] sh;
      logic        nq;
      sh = {r[30:0], t};
      if (q == m) s = {1'b0, sh} - {1'b0, d};
      else        s = {1'b0, sh} + {1'b0, d};
      nq = r[31] ^ s[32] ^ m;
      return {s[31:0], nq, (nq == m)};
   endfunction

   task automatic issue(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b);
      start = 1'b1; op = o; rem_in = a; divisor = b;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic do_setu();
      logic [31:0] prev;
      prev = rem_out;
      issue(2'b01, $urandom, $urandom);
      mq = 0; mm = 0; mt = 0;
      check("R2 flags", {29'd0, q_flag, m_flag, t_flag}, 32'd0);
      check("R2 rem", rem_out, prev);
   endtask

   task automatic do_sets(input logic [31:0] a, input logic [31:0] b);
      logic [31:0] prev;
      prev = rem_out;
      issue(2'b10, a, b);
      mq = a[31]; mm = b[31]; mt = a[31] ^ b[31];
      check("R3 flags", {29'd0, q_flag, m_flag, t_flag}, {29'd0, mq, mm, mt});
      check("R3 rem", rem_out, prev);
   endtask

   task automatic do_step(input logic [31:0] a, input logic [31:0] b);
      logic [33:0] e;
      e = ref_step(a, b, mq, mm, mt);
      issue(2'b00, a, b);
      mq = e[1]; mt = e[0];
      check("R4 rem", rem_out, e[33:2]);
      check("R5 q", {31'd0, q_flag}, {31'd0, mq});
      check("R5 m", {31'd0, m_flag}, {31'd0, mm});
      check("R6 t", {31'd0, t_flag}, {31'd0, mt});
   endtask

   task automatic do_run(input logic [31:0] a, input logic [31:0] b, input bit inject);
      int k;
      int nb;
      issue(2'b11, a, b);
      k = 1; nb = 0;
      while (!done && k < 40) begin
         if (busy) nb++;
         if (inject && k == 10) begin
            start = 1'b1; op = 2'b10; rem_in = 32'hFFFF_FFFF;
         end
         @(negedge clk);
         if (inject && k == 10) begin
            start = 1'b0;
            check("R9 m during run", {31'd0, m_flag}, 32'd0);
         end
         k++;
      end
      check("R7 done cycle", k, 33);
      check("R7 busy cycles", nb, 32);
      check("R8 quotient", quot, a / b);
      if (inject) check("R9 quotient", quot, a / b);
      @(negedge clk);
      check("R7 done pulse", {30'd0, done, busy}, 32'd0);
      do_setu();
   endtask

   initial begin
      #(20 * 200000);
      nfail++;
      $display("FAIL R7 watchdog act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      check("R1 rem", rem_out, 32'd0);
      check("R1 quot", quot, 32'd0);
      check("R1 status", {27'd0, q_flag, m_flag, t_flag, busy, done}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // directed steps and setups
      do_setu();
      do_step(32'h0000_0000, 32'h0000_0001);
      do_step(32'hFFFF_FFFF, 32'h0000_0001);
      do_step(32'h8000_0000, 32'h7FFF_FFFF);
      do_sets(32'h8000_0000, 32'h0000_0003);
      do_step(32'h8000_0000, 32'h0000_0003);
      do_step(32'h7FFF_FFFF, 32'hFFFF_FFFF);
      do_sets(32'hF000_0000, 32'h8000_0001);
      do_step(32'hF000_0000, 32'h8000_0001);
      do_sets(32'h1234_5678, 32'h0000_0009);
      do_step(32'h1234_5678, 32'h0000_0009);

      // random step / setup mix
      for (int i = 0; i < 300; i++) begin
         int sel;
         sel = $urandom % 8;
         if (sel == 0)      do_setu();
         else if (sel == 1) do_sets($urandom, $urandom);
         else               do_step($urandom, $urandom);
      end

      // directed full runs
      do_run(32'h0000_0000, 32'h0000_0001, 1'b0);
      do_run(32'hFFFF_FFFF, 32'h0000_0001, 1'b0);
      do_run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
      do_run(32'h0000_0005, 32'h0000_0007, 1'b0);
      do_run(32'h8000_0000, 32'h0000_0003, 1'b0);
      do_run(32'h7FFF_FFFF, 32'h8000_0000, 1'b0);
      do_run(32'hFFFF_FFF0, 32'h8000_0001, 1'b1);

      // random runs
      for (int i = 0; i < 40; i++) begin
         logic [31:0] a, b;
         a = $urandom;
         b = (i % 2 == 0) ? ($urandom | 32'd1) : (($urandom & 32'hFF) | 32'd1);
         do_run(a, b, (i % 5 == 0));
      end

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule